// File: doc/BRIEF.md
# Four-Channel PWM Generator with Shadowed Settings

The block produces four independent pulse-width-modulated outputs. Each channel has a 16-bit period, a 16-bit duty count and a control word. The control word holds a prescaler code and an output polarity bit. All channels advance on a shared 1 MHz tick enable. The prescaler divides that tick by 1, 2, 4 or 8 before the channel's period counter sees it.

Software writes configuration through a single-cycle register port. Control and duty writes land in shadow storage. A period write arms a commit. A running channel takes the armed settings only when its current period has finished, so a waveform never shows a mix of old and new settings. An idle channel takes them at once.

Writing a period of 0 stops the channel in the same way: the running period completes, and then the output stays low. Reads return the shadow values.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset, every output is low, every channel is idle and every register reads 0.
- R2: Byte address 0x400+4*ch is the period register, 0x420+4*ch is duty and 0x440+4*ch is control (ch = 0..3). Reads return the last written value. Control reads back only bits [1:0] (prescaler code) and bit 5 (invert); all other bits read 0. Unmapped addresses read 0.
- R3: When an idle channel gets a nonzero period write, it loads all shadow settings in the next cycle and starts counting from 0.
- R4: Prescaler code d (0..3) makes each count step last 2^d active ticks. A period of P therefore lasts P*2^d ticks.
- R5: While the count is below duty, the output is at its active level, which is high. Control bit 5 set makes the active level low.
- R6: Duty and control writes without a following period write never change an output.
- R7: After a period write to a running channel, the new settings apply from the first count of the next period. The current period runs to its end unchanged.
- R8: After a period write of 0, the current period completes. From then on the output is low, whatever the polarity.
- R9: A duty of 0 gives a constant inactive level. A duty equal to the period gives a constant active level.
- R10: In cycles with the tick enable low, no counter or output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 MHz count enable, one clock wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i, combinational |
| pwm_o | output | 4 | PWM outputs, one bit per channel |

## Verification
The hardest case is a period write to a running channel followed by more shadow writes before the boundary. The stimulus writes duty, control and then period in the middle of a period. It then rewrites the channel into an inverted, slower-prescaled setting and finally into a zero period, all while the old waveform is still running. A cycle-level reference model in the bench follows the same commit rules and compares all four outputs on every clock. Slow ticks are mixed with full-rate ticks so that boundary handling is seen both with and without idle cycles in between.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // address block ids: byte address bits [11:5]
  localparam int BLK_PER  = 'h20;
  localparam int BLK_DUTY = 'h21;
  localparam int BLK_CTRL = 'h22;
  localparam int INV_BIT  = 5;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PER,
    SEL_DUTY,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [NUM_CH-1:0]             load_i,
  output logic [NUM_CH-1:0]             pend_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  sh_per_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  sh_duty_o,
  output logic [NUM_CH-1:0][DIV_W-1:0]  sh_div_o,
  output logic [NUM_CH-1:0]             sh_inv_o
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BLK_W = ADDR_W - 5;

  reg_sel_e          sel;
  logic [2:0]        slot;
  logic [CH_W-1:0]   chan;
  logic [NUM_CH-1:0] wr_per, wr_duty, wr_ctrl;

  assign slot = addr_i[4:2];
  assign chan = slot[CH_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (addr_i[1:0] == 2'b00 && int'(slot) < NUM_CH) begin
      if (addr_i[ADDR_W-1:5] == BLK_W'(BLK_PER))       sel = SEL_PER;
      else if (addr_i[ADDR_W-1:5] == BLK_W'(BLK_DUTY)) sel = SEL_DUTY;
      else if (addr_i[ADDR_W-1:5] == BLK_W'(BLK_CTRL)) sel = SEL_CTRL;
    end
  end

  always_comb begin
    wr_per  = '0;
    wr_duty = '0;
    wr_ctrl = '0;
    if (we_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(chan) == c) begin
          wr_per[c]  = (sel == SEL_PER);
          wr_duty[c] = (sel == SEL_DUTY);
          wr_ctrl[c] = (sel == SEL_CTRL);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_per_o  <= '0;
      sh_duty_o <= '0;
      sh_div_o  <= '0;
      sh_inv_o  <= '0;
      pend_o    <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_per[c])  sh_per_o[c]  <= wdata_i[CNT_W-1:0];
        if (wr_duty[c]) sh_duty_o[c] <= wdata_i[CNT_W-1:0];
        if (wr_ctrl[c]) begin
          sh_div_o[c] <= wdata_i[DIV_W-1:0];
          sh_inv_o[c] <= wdata_i[INV_BIT];
        end
        // a new period write wins over a same-cycle commit
        if (wr_per[c])      pend_o[c] <= 1'b1;
        else if (load_i[c]) pend_o[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_PER:  rdata_o[CNT_W-1:0] = sh_per_o[chan];
      SEL_DUTY: rdata_o[CNT_W-1:0] = sh_duty_o[chan];
      SEL_CTRL: begin
        rdata_o[DIV_W-1:0] = sh_div_o[chan];
        rdata_o[INV_BIT]   = sh_inv_o[chan];
      end
      default:  rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_pend_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i[g] && !wr_per[g]) |=> !pend_o[g]);
    p_pend_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_per[g] |=> pend_o[g]);
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pend_i,
  input  logic [CNT_W-1:0] sh_per_i,
  input  logic [CNT_W-1:0] sh_duty_i,
  input  logic [DIV_W-1:0] sh_div_i,
  input  logic             sh_inv_i,
  output logic             load_o,
  output logic             pwm_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic             run_q, inv_q;
  logic [CNT_W-1:0] per_q, duty_q, cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q, pre_last;
  logic             step, at_end;

  assign pre_last = ~({PRE_W{1'b1}} << div_q);
  assign step     = run_q && tick_i && (pre_q == pre_last);
  assign at_end   = step && (cnt_q == per_q - CNT_W'(1));
  assign load_o   = pend_i && (!run_q || at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      inv_q  <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
    end else if (load_o) begin
      run_q  <= (sh_per_i != '0);
      per_q  <= sh_per_i;
      duty_q <= sh_duty_i;
      div_q  <= sh_div_i;
      inv_q  <= sh_inv_i;
      cnt_q  <= '0;
      pre_q  <= '0;
    end else if (run_q && tick_i) begin
      if (step) begin
        pre_q <= '0;
        cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign pwm_o = run_q && ((cnt_q < duty_q) ^ inv_q);

  p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !pwm_o);
  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < per_q));
  p_hold_no_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_o) |=> ($stable(cnt_q) && $stable(pre_q) && $stable(pwm_o)));
  p_cfg_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> ($stable(duty_q) && $stable(div_q) && $stable(inv_q) && $stable(per_q)));
  p_load_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (cnt_q == '0 && pre_q == '0));
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH-1:0]            load, pend, sh_inv;
  logic [NUM_CH-1:0][CNT_W-1:0] sh_per, sh_duty;
  logic [NUM_CH-1:0][DIV_W-1:0] sh_div;

  pwm_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DIV_W(DIV_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .load_i(load), .pend_o(pend),
    .sh_per_o(sh_per), .sh_duty_o(sh_duty), .sh_div_o(sh_div), .sh_inv_o(sh_inv)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
      .clk_i, .rst_ni, .tick_i,
      .pend_i(pend[g]),
      .sh_per_i(sh_per[g]), .sh_duty_i(sh_duty[g]),
      .sh_div_i(sh_div[g]), .sh_inv_i(sh_inv[g]),
      .load_o(load[g]), .pwm_o(pwm_o[g])
    );
  end
endmodule

// File: tb/sim_pwm_shadow_ctrl.sv
module sim_pwm_shadow_ctrl;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;

  logic        clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  pwm;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;
  int tick_mode = 0, tick_ph = 0;

  pwm_shadow_ctrl u0 (
    .clk_i(clk), .rst_ni, .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model state
  int m_per[NCH], m_duty[NCH], m_div[NCH], m_inv[NCH], m_run[NCH], m_cnt[NCH], m_pre[NCH];
  int s_per[NCH], s_duty[NCH], s_ctrl[NCH], pend[NCH];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        m_per[c] = 0; m_duty[c] = 0; m_div[c] = 0; m_inv[c] = 0; m_run[c] = 0;
        m_cnt[c] = 0; m_pre[c] = 0; s_per[c] = 0; s_duty[c] = 0; s_ctrl[c] = 0; pend[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit ld;
        ld = 0;
        if (m_run[c] == 0) ld = (pend[c] != 0);
        else if (tick) begin
          if (m_pre[c] == (1 << m_div[c]) - 1) begin
            m_pre[c] = 0;
            if (m_cnt[c] == m_per[c] - 1) begin
              m_cnt[c] = 0;
              ld = (pend[c] != 0);
            end else m_cnt[c]++;
          end else m_pre[c]++;
        end
        if (ld) begin
          m_per[c] = s_per[c]; m_duty[c] = s_duty[c];
          m_div[c] = s_ctrl[c] & 3; m_inv[c] = (s_ctrl[c] >> 5) & 1;
          m_run[c] = (s_per[c] != 0); m_cnt[c] = 0; m_pre[c] = 0; pend[c] = 0;
        end
      end
      if (we && addr[1:0] == 2'b00 && addr[4:2] < NCH) begin
        int c;
        c = int'(addr[4:2]);
        case (int'(addr[11:5]))
          'h20: begin s_per[c] = wdata[15:0]; pend[c] = 1; end
          'h21: s_duty[c] = wdata[15:0];
          'h22: s_ctrl[c] = wdata & 32'h23;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [3:0] model_out();
    logic [3:0] o;
    for (int c = 0; c < NCH; c++)
      o[c] = (m_run[c] != 0) && (((m_cnt[c] < m_duty[c]) ? 1 : 0) != m_inv[c]);
    return o;
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (pwm !== model_out()) begin
        errors++;
        $display("FAIL %s pwm_o actual %b expected %b at %0t", tag, pwm, model_out(), $time);
      end
    end
    tick_ph++;
    tick <= (tick_mode == 0) ? 1'b1 : (tick_ph % 2 == 0);
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    #1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    #1; we = 1'b0;
  endtask

  task automatic rd_chk(input string t, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    #1; addr = a;
    #1; chk(t, rdata, exp);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] a_per(input int c);  return 12'(32'h400 + 4*c); endfunction
  function automatic logic [11:0] a_duty(input int c); return 12'(32'h420 + 4*c); endfunction
  function automatic logic [11:0] a_ctrl(input int c); return 12'(32'h440 + 4*c); endfunction

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R1 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run(3);
    #2; chk("R1 reset out", 32'(pwm), 0);
    rst_ni = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      rd_chk("R1 per", a_per(c), 0);
      rd_chk("R1 duty", a_duty(c), 0);
      rd_chk("R1 ctrl", a_ctrl(c), 0);
    end
    cmp_on = 1'b1;

    tag = "R2";
    wr(a_duty(1), 32'h1234);
    wr(a_ctrl(1), 32'hFFFF_FFFF);
    rd_chk("R2 duty rb", a_duty(1), 32'h1234);
    rd_chk("R2 ctrl mask", a_ctrl(1), 32'h23);
    rd_chk("R2 unmapped", 12'h460, 0);
    tag = "R6";
    run(20);
    chk("R6 no commit", 32'(pwm), 0);
    wr(a_ctrl(1), 0);
    wr(a_duty(1), 0);

    tag = "R3";
    wr(a_duty(0), 3);
    wr(a_per(0), 8);
    rd_chk("R2 per rb", a_per(0), 8);
    run(40);

    tag = "R4";
    wr(a_ctrl(2), 2);
    wr(a_duty(2), 2);
    wr(a_per(2), 5);
    run(60);
    tag = "R10";
    tick_mode = 1;
    run(120);
    tick_mode = 0;

    tag = "R5";
    wr(a_ctrl(3), 32'h20);
    wr(a_duty(3), 1);
    wr(a_per(3), 4);
    run(30);

    tag = "R7";
    run(3);
    wr(a_duty(0), 6);
    wr(a_ctrl(0), 32'h21);
    wr(a_per(0), 10);
    wr(a_ctrl(0), 32'h23);
    run(70);
    wr(a_per(0), 7);
    run(80);

    tag = "R9";
    wr(a_duty(1), 0);
    wr(a_per(1), 6);
    wr(a_ctrl(3), 0);
    wr(a_duty(3), 4);
    wr(a_per(3), 4);
    run(40);
    chk("R9 duty zero", 32'(pwm[1]), 0);
    chk("R9 duty full", 32'(pwm[3]), 1);

    tag = "R8";
    wr(a_ctrl(2), 32'h20);
    wr(a_per(2), 5);
    run(3);
    for (int c = 0; c < NCH; c++) wr(a_per(c), 0);
    tick_mode = 1;
    run(200);
    chk("R8 parked low", 32'(pwm), 0);
    tick_mode = 0;
    run(5);

    cmp_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule